// File: doc/BRIEF.md
# Hardware Thread Context Scheduler

This block picks, on every cycle, which of four hardware thread contexts may issue an instruction into a small RISC pipeline. Thread 0 is the interrupt context. The pipeline uses the thread number it puts out to select a register bank and a program counter. A valid flag tells the pipeline whether that issue slot is usable.

There are two modes. In explicit mode one thread runs on its own. The scheduler changes thread only when software asks for a named target, or when an interrupt arrives. On an interrupt it saves the thread that was running, runs thread 0 for the service routine, and goes back to the saved thread when the routine returns. In interleaved mode the active threads take turns, one per cycle, in ascending order. An interrupt there is served in thread 0's own slot, and the other threads keep issuing in their turns.

Software controls which threads are enabled through activate and deactivate commands. After reset only thread 0 is enabled.

Top module: `thread_ctx_sched`

## Requirements
- R1: After reset, `tid_o`=0, `valid_o`=1, `in_isr_o`=0 and `sw_err_o`=0, and only thread 0 is enabled. Thread 0 is always enabled: a deactivate command naming thread 0 has no effect.
- R2: A pulse on `act_i` or `deact_i` enables or disables the thread whose binary number is on `act_tid_i` or `deact_tid_i`. The change is used from the next cycle on. If both commands name the same thread in the same cycle, activate wins.
- R3: `mode_i`=0 selects explicit mode. In that mode, a `sw_req_i` whose target on `sw_tid_i` is an enabled, non-zero thread is accepted when no service routine is running and `irq_i` is low. After the next edge, `tid_o` equals the target and `valid_o`=0 for exactly one cycle.
- R4: In explicit mode, when there is no request, no interrupt and no return, `tid_o` holds its value.
- R5: A `sw_req_i` in explicit mode whose target is thread 0 or a disabled thread is ignored, and `sw_err_o` is high for the one cycle after it.
- R6: In explicit mode, `irq_i` while no service routine is running makes `tid_o`=0 and `in_isr_o`=1 after the next edge, with `valid_o`=1. While the routine runs, switch requests to valid targets are ignored and raise no error.
- R7: In explicit mode, `rti_i` while `in_isr_o`=1 restores the saved thread number on `tid_o` and clears `in_isr_o` at the next edge.
- R8: `mode_i`=1 selects interleaved mode. In that mode `tid_o` moves every cycle to the next enabled thread in ascending order, wrapping from 3 to 0 and skipping disabled threads, and `valid_o`=1.
- R9: In interleaved mode, when thread 0 is the only enabled thread, it issues on every cycle.
- R10: In interleaved mode, `irq_i` sets `in_isr_o`, so thread 0's slots run the service routine. Threads 1 to 3 keep rotating while it runs, and `rti_i` clears `in_isr_o`.
- R11: In interleaved mode, `sw_req_i` has no effect on the rotation and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 explicit mode, 1 interleaved mode |
| sw_req_i | input | 1 | Software switch request strobe |
| sw_tid_i | input | 2 | Switch target thread |
| act_i | input | 1 | Activate command strobe |
| act_tid_i | input | 2 | Thread to activate |
| deact_i | input | 1 | Deactivate command strobe |
| deact_tid_i | input | 2 | Thread to deactivate |
| irq_i | input | 1 | Interrupt request |
| rti_i | input | 1 | Return-from-interrupt strobe |
| tid_o | output | 2 | Thread issuing this cycle |
| valid_o | output | 1 | Issue slot is usable (low on a switch bubble) |
| in_isr_o | output | 1 | Thread 0 is running the service routine |
| sw_err_o | output | 1 | Previous switch request was rejected |

## Verification
The bench builds the block with its default of four thread contexts and a two-bit thread number. This lets every rotation pattern be hand-checked: thread 0 alone, two threads, and three threads with a gap at thread 2. At this size the bench can also reach a switch to a thread that was enabled and then disabled, and a request to deactivate thread 0 that must have no effect. It also covers switch requests made during a service routine, and a change of mode while a non-zero thread is current.

// File: rtl/tsched_pkg.sv
package tsched_pkg;

    typedef enum logic {
        MODE_EXPLICIT = 1'b0,
        MODE_ILV      = 1'b1
    } sched_mode_e;

endpackage

// File: rtl/tsched_active_mask.sv
module tsched_active_mask #(
    parameter int NUM_THREADS = 4,
    localparam int TID_W = $clog2(NUM_THREADS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   act_i,
    input  logic [TID_W-1:0]       act_tid_i,
    input  logic                   deact_i,
    input  logic [TID_W-1:0]       deact_tid_i,
    output logic [NUM_THREADS-1:0] mask_o
);

    // Thread 0 carries interrupts and can never be disabled (R1)
    assign mask_o[0] = 1'b1;

    for (genvar g = 1; g < NUM_THREADS; g++) begin : g_bit
        logic en_d, en_q;

        always_comb begin
            en_d = en_q;
            if (deact_i && deact_tid_i == TID_W'(g)) en_d = 1'b0;
            if (act_i && act_tid_i == TID_W'(g))     en_d = 1'b1;   // R2: activate wins
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= en_d;
        end

        assign mask_o[g] = en_q;
    end

endmodule

// File: rtl/tsched_rr_pick.sv
module tsched_rr_pick #(
    parameter int NUM_THREADS = 4,
    localparam int TID_W = $clog2(NUM_THREADS)
) (
    input  logic [TID_W-1:0]       cur_i,
    input  logic [NUM_THREADS-1:0] mask_i,
    output logic [TID_W-1:0]       nxt_o
);

    // Scan offsets from the far end down, so that the nearest enabled
    // thread after the current one is the last one written (R8)
    always_comb begin
        nxt_o = cur_i;
        for (int k = NUM_THREADS; k >= 1; k--) begin
            logic [TID_W-1:0] idx;
            idx = TID_W'((int'(cur_i) + k) % NUM_THREADS);
            if (mask_i[idx]) nxt_o = idx;
        end
    end

endmodule

// File: rtl/thread_ctx_sched.sv
module thread_ctx_sched
    import tsched_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    localparam int TID_W = $clog2(NUM_THREADS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             sw_req_i,
    input  logic [TID_W-1:0] sw_tid_i,
    input  logic             act_i,
    input  logic [TID_W-1:0] act_tid_i,
    input  logic             deact_i,
    input  logic [TID_W-1:0] deact_tid_i,
    input  logic             irq_i,
    input  logic             rti_i,
    output logic [TID_W-1:0] tid_o,
    output logic             valid_o,
    output logic             in_isr_o,
    output logic             sw_err_o
);

    typedef struct packed {
        logic [TID_W-1:0] tid;
        logic [TID_W-1:0] saved;
        logic             in_isr;
        logic             valid;
        logic             err;
    } sched_state_t;

    sched_state_t           st_d, st_q;
    logic [NUM_THREADS-1:0] act_mask;
    logic [TID_W-1:0]       rr_next;
    logic                   tgt_bad;
    sched_mode_e            mode;

    assign mode = sched_mode_e'(mode_i);

    tsched_active_mask #(.NUM_THREADS(NUM_THREADS)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_i       (act_i),
        .act_tid_i   (act_tid_i),
        .deact_i     (deact_i),
        .deact_tid_i (deact_tid_i),
        .mask_o      (act_mask)
    );

    tsched_rr_pick #(.NUM_THREADS(NUM_THREADS)) u_pick (
        .cur_i  (st_q.tid),
        .mask_i (act_mask),
        .nxt_o  (rr_next)
    );

    assign tgt_bad = (sw_tid_i == '0) || !act_mask[sw_tid_i];

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b1;
        st_d.err   = 1'b0;
        if (mode == MODE_ILV) begin
            st_d.tid = rr_next;
            if (!st_q.in_isr && irq_i)     st_d.in_isr = 1'b1;
            else if (st_q.in_isr && rti_i) st_d.in_isr = 1'b0;
        end else begin
            st_d.err = sw_req_i && tgt_bad;
            if (st_q.in_isr) begin
                if (rti_i) begin
                    st_d.tid    = st_q.saved;
                    st_d.in_isr = 1'b0;
                end
            end else if (irq_i) begin
                st_d.saved  = st_q.tid;
                st_d.tid    = '0;
                st_d.in_isr = 1'b1;
            end else if (sw_req_i && !tgt_bad) begin
                st_d.tid   = sw_tid_i;
                st_d.valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tid    <= '0;
            st_q.saved  <= '0;
            st_q.in_isr <= 1'b0;
            st_q.valid  <= 1'b1;
            st_q.err    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tid_o    = st_q.tid;
    assign valid_o  = st_q.valid;
    assign in_isr_o = st_q.in_isr;
    assign sw_err_o = st_q.err;

    p_switch_bubble_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && sw_req_i && sw_tid_i != '0 && act_mask[sw_tid_i] && !in_isr_o && !irq_i)
        |=> (!valid_o && tid_o == $past(sw_tid_i)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && !sw_req_i && !irq_i && !rti_i) |=> $stable(tid_o));

    p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && sw_req_i && sw_tid_i == '0) |=> sw_err_o);

    p_irq_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && irq_i && !in_isr_o) |=> (tid_o == '0 && in_isr_o && valid_o));

    p_rti_leave_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && rti_i && in_isr_o) |=> !in_isr_o);

    p_ilv_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |=> valid_o);

    p_ilv_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && irq_i && !in_isr_o) |=> in_isr_o);

    p_ilv_noerr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |=> !sw_err_o);

endmodule

// File: tb/thread_ctx_sched_bench.sv
module thread_ctx_sched_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    tid;
        bit    v;
        bit    isr;
        bit    err;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_i = 1'b0, sw_req_i = 1'b0, act_i = 1'b0, deact_i = 1'b0;
    logic       irq_i = 1'b0, rti_i = 1'b0;
    logic [1:0] sw_tid_i = '0, act_tid_i = '0, deact_tid_i = '0;
    logic [1:0] tid_o;
    logic       valid_o, in_isr_o, sw_err_o;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    thread_ctx_sched u_thread_ctx_sched (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .sw_req_i(sw_req_i), .sw_tid_i(sw_tid_i),
        .act_i(act_i), .act_tid_i(act_tid_i),
        .deact_i(deact_i), .deact_tid_i(deact_tid_i),
        .irq_i(irq_i), .rti_i(rti_i),
        .tid_o(tid_o), .valid_o(valid_o), .in_isr_o(in_isr_o), .sw_err_o(sw_err_o)
    );

    task automatic compare(input exp_t e);
        n_checks++;
        if (int'(tid_o) != e.tid || valid_o != e.v || in_isr_o != e.isr || sw_err_o != e.err) begin
            n_errors++;
            $display("FAIL %s: tid/valid/isr/err actual %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
                     e.tag, tid_o, valid_o, in_isr_o, sw_err_o, e.tid, e.v, e.isr, e.err);
        end
    endtask

    // Monitor: one expected item per clock edge, sampled after the edge settles
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) compare(sb_q.pop_front());
    end

    // Driver: apply one cycle of stimulus and queue the outcome due after the next edge
    task automatic tick(input bit mode, input bit sw, input int swt,
                        input bit act, input int actt, input bit dct, input int dctt,
                        input bit irq, input bit rti,
                        input int etid, input bit ev, input bit eisr, input bit eerr,
                        input string tag);
        exp_t e;
        @(negedge clk);
        mode_i = mode; sw_req_i = sw; sw_tid_i = 2'(swt);
        act_i = act; act_tid_i = 2'(actt); deact_i = dct; deact_tid_i = 2'(dctt);
        irq_i = irq; rti_i = rti;
        e.tid = etid; e.v = ev; e.isr = eisr; e.err = eerr; e.tag = tag;
        sb_q.push_back(e);
    endtask

    initial begin
        int cnt = 0;
        while (!done && cnt < 5000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        r.tid = 0; r.v = 1; r.isr = 0; r.err = 0; r.tag = "R1 reset";
        compare(r);

        // explicit mode          m sw swt ac at dc dt irq rti  tid v isr err
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0,  0, 1, 0, 0, "R1 idle T0");
        tick(0, 1, 2, 0, 0, 0, 0, 0, 0,  0, 1, 0, 1, "R5 inactive target");
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0,  0, 1, 0, 0, "R5 error one cycle");
        tick(0, 1, 0, 0, 0, 0, 0, 0, 0,  0, 1, 0, 1, "R5 target T0");
        tick(0, 0, 0, 1, 2, 0, 0, 0, 0,  0, 1, 0, 0, "R2 activate T2");
        tick(0, 1, 2, 0, 0, 0, 0, 0, 0,  2, 0, 0, 0, "R3 switch bubble");
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0,  2, 1, 0, 0, "R3 after bubble");
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0,  2, 1, 0, 0, "R4 hold");
        tick(0, 0, 0, 0, 0, 0, 0, 1, 0,  0, 1, 1, 0, "R6 irq to T0");
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0,  0, 1, 1, 0, "R6 in service");
        tick(0, 1, 2, 0, 0, 0, 0, 0, 0,  0, 1, 1, 0, "R6 switch ignored in isr");
        tick(0, 0, 0, 0, 0, 0, 0, 0, 1,  2, 1, 0, 0, "R7 return to T2");
        tick(0, 0, 0, 0, 0, 1, 2, 0, 0,  2, 1, 0, 0, "R2 deactivate T2");
        tick(0, 1, 2, 0, 0, 0, 0, 0, 0,  2, 1, 0, 1, "R2 disabled target rejected");
        tick(0, 0, 0, 0, 0, 1, 0, 0, 0,  2, 1, 0, 0, "R1 deactivate T0");

        // interleaved mode
        tick(1, 0, 0, 1, 1, 0, 0, 0, 0,  0, 1, 0, 0, "R1 T0 still enabled");
        tick(1, 0, 0, 0, 0, 0, 0, 0, 0,  1, 1, 0, 0, "R8 rotate 0-1");
        tick(1, 0, 0, 0, 0, 0, 0, 0, 0,  0, 1, 0, 0, "R8 rotate 1-0");
        tick(1, 0, 0, 0, 0, 0, 0, 0, 0,  1, 1, 0, 0, "R8 rotate 0-1 again");
        tick(1, 0, 0, 1, 3, 0, 0, 0, 0,  0, 1, 0, 0, "R8 activate T3");
        tick(1, 0, 0, 0, 0, 0, 0, 0, 0,  1, 1, 0, 0, "R8 three threads");
        tick(1, 0, 0, 0, 0, 0, 0, 0, 0,  3, 1, 0, 0, "R8 skip T2");
        tick(1, 0, 0, 0, 0, 0, 0, 0, 0,  0, 1, 0, 0, "R8 wrap to T0");
        tick(1, 0, 0, 0, 0, 0, 0, 1, 0,  1, 1, 1, 0, "R10 irq taken");
        tick(1, 0, 0, 0, 0, 0, 0, 0, 0,  3, 1, 1, 0, "R10 T3 keeps turn");
        tick(1, 0, 0, 0, 0, 0, 0, 0, 0,  0, 1, 1, 0, "R10 T0 slot serves isr");
        tick(1, 0, 0, 0, 0, 0, 0, 0, 1,  1, 1, 0, 0, "R10 return");
        tick(1, 1, 3, 0, 0, 0, 0, 0, 0,  3, 1, 0, 0, "R11 switch ignored");
        tick(1, 1, 0, 0, 0, 0, 0, 0, 0,  0, 1, 0, 0, "R11 no error");
        tick(1, 0, 0, 0, 0, 1, 1, 0, 0,  1, 1, 0, 0, "R2 deactivate T1");
        tick(1, 0, 0, 0, 0, 1, 3, 0, 0,  3, 1, 0, 0, "R2 deactivate T3");
        tick(1, 0, 0, 0, 0, 0, 0, 0, 0,  0, 1, 0, 0, "R9 only T0");
        tick(1, 0, 0, 0, 0, 0, 0, 0, 0,  0, 1, 0, 0, "R9 T0 every cycle");
        tick(1, 0, 0, 0, 0, 0, 0, 0, 0,  0, 1, 0, 0, "R9 T0 repeats");

        tick(0, 0, 0, 0, 0, 0, 0, 0, 0,  0, 1, 0, 0, "R4 back to explicit");
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0,  0, 1, 0, 0, "R4 hold T0");

        @(negedge clk);
        mode_i = 1'b0; sw_req_i = 1'b0; act_i = 1'b0; deact_i = 1'b0; irq_i = 1'b0; rti_i = 1'b0;
        while (sb_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule